// File: doc/BRIEF.md
# Masked Multi-Channel Interrupt Aggregator

This block gathers the interrupt request lines of sixteen serial channels into one status vector. Each request line is level-sensitive. The block registers the request lines once per clock and applies a per-channel mask, in which a set bit blocks that channel. It drives one interrupt output, and a single global enable gates that output. A request clears only when its channel drops the line; nothing in this block latches or clears a request.

Software programs the block through a simple write strobe with an address and a data word. It reads the block through a combinational read port that returns either the raw status or the mask. The mask comes out of reset with every channel blocked, and the global enable comes out of reset off. Software therefore unmasks the channels it serves and sets the enable bit before any interrupt can reach the output. All pins are plain control and status signals, and no data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Register map (word address on `wr_addr`/`rd_addr`): 0 is the raw status (read only), 1 is the channel mask, and 2 is the control word. Only bit 20 of the control word holds state; it is the global enable.

Top module: `chan_irq_merge`

## Requirements
- R1: After reset, the mask register (address 1) reads 0x0000FFFF, so all channels are blocked. The global enable is 0, and `irq` is 0.
- R2: Bits 15:0 of a read at address 0 equal `chan_req` as sampled at the previous rising clock edge. Bits 31:16 of that read are 0.
- R3: A write at address 1 loads `wr_data[15:0]` into the mask, and a read at address 1 returns it in bits 15:0 with bits 31:16 at 0. A mask bit of 1 blocks its channel; a mask bit of 0 passes it.
- R4: `irq` is 1 exactly when the global enable is 1 and at least one channel has both its status bit at 1 and its mask bit at 0.
- R5: A write at address 2 loads the global enable from `wr_data[20]`. All other bits of that write have no effect.
- R6: A mask or enable write changes `irq` only after the rising edge that captures the write, not while the write strobe is still pending.
- R7: A write at address 0 has no effect on the status, on the mask or on `irq`.
- R8: A status bit follows its request line level-wise. When the line drops, the bit reads 0 after the next edge, and `irq` falls if no other unmasked channel is pending.
- R9: A read at address 2 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| chan_req | input | 16 | Level interrupt request lines, one per channel |
| irq | output | 1 | Aggregated interrupt output |

## Verification
A wrong bit in the mask register shows at the read port at address 1 right after the write edge. It also shows as `irq` asserting or failing to assert on the first edge after that channel's request rises. A stuck or stale status bit shows at address 0 one clock after the request line changes. A global enable that is lost or set by the wrong bit shows on `irq` within one edge of a pending unmasked request. The bench therefore checks each register write and each request change after exactly one edge, and it also checks the value before that edge for the timing requirement.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_CTRL   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/chan_irq_sample.sv
module chan_irq_sample #(
  parameter int unsigned N_CHAN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CHAN-1:0] req_i,
  output logic [N_CHAN-1:0] status_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= req_i;
  end
endmodule

// File: rtl/chan_irq_cfg.sv
module chan_irq_cfg
  import chan_irq_pkg::*;
#(
  parameter int unsigned N_CHAN = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_BIT = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [N_CHAN-1:0]     mask_o,
  output logic                  en_o
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  logic hit_mask, hit_ctrl;
  assign hit_mask = wr_en && (reg_sel_e'(wr_addr) == REG_MASK);
  assign hit_ctrl = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '1;
      en_o   <= 1'b0;
    end else begin
      if (hit_mask) mask_o <= wr_data[N_CHAN-1:0];
      if (hit_ctrl) en_o   <= wr_data[EN_BIT];
    end
  end
endmodule

// File: rtl/chan_irq_reduce.sv
module chan_irq_reduce #(
  parameter int unsigned N_CHAN = 16
) (
  input  logic [N_CHAN-1:0] status_i,
  input  logic [N_CHAN-1:0] mask_i,
  input  logic              en_i,
  output logic              irq_o
);
  logic [N_CHAN-1:0] pend;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_pend
    assign pend[g] = status_i[g] & ~mask_i[g];
  end

  assign irq_o = en_i & (|pend);
endmodule

// File: rtl/chan_irq_merge.sv
module chan_irq_merge
  import chan_irq_pkg::*;
#(
  parameter int unsigned N_CHAN = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_BIT = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [N_CHAN-1:0]     chan_req,
  output logic                  irq
);
  localparam int unsigned PAD_W = DATA_W - N_CHAN;

  logic [N_CHAN-1:0] status_q;
  logic [N_CHAN-1:0] mask_q;
  logic              en_q;

  chan_irq_sample #(.N_CHAN(N_CHAN)) u_sample (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (chan_req),
    .status_o (status_q)
  );

  chan_irq_cfg #(.N_CHAN(N_CHAN), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mask_o  (mask_q),
    .en_o    (en_q)
  );

  chan_irq_reduce #(.N_CHAN(N_CHAN)) u_reduce (
    .status_i (status_q),
    .mask_i   (mask_q),
    .en_i     (en_q),
    .irq_o    (irq)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      REG_STATUS: rd_data = {{PAD_W{1'b0}}, status_q};
      REG_MASK:   rd_data = {{PAD_W{1'b0}}, mask_q};
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/chan_irq_merge_chk.sv
module chan_irq_merge_chk #(
  parameter int unsigned N_CHAN = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_BIT = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [N_CHAN-1:0] chan_req,
  input logic [N_CHAN-1:0] status_q,
  input logic [N_CHAN-1:0] mask_q,
  input logic              en_q,
  input logic              irq
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mask_q == '1 && !en_q));

  p_status_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> status_q == $past(chan_req));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> mask_q == $past(wr_data[N_CHAN-1:0]));

  p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(status_q & ~mask_q));

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq);

  p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> en_q == $past(wr_data[EN_BIT]));

  p_status_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (mask_q == $past(mask_q) && en_q == $past(en_q)));
endmodule

bind chan_irq_merge chan_irq_merge_chk #(
  .N_CHAN(N_CHAN), .DATA_W(DATA_W), .EN_BIT(EN_BIT)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .chan_req (chan_req),
  .status_q (status_q),
  .mask_q   (mask_q),
  .en_q     (en_q),
  .irq      (irq)
);

// File: tb/test_chan_irq_merge.sv
module test_chan_irq_merge;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] chan_req = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_irq_merge i_chan_irq_merge (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .chan_req(chan_req), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic set_req(input logic [15:0] r);
    @(negedge clk);
    chan_req = r;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_read(2'd1, d);
    check("R1", "mask after reset", d, 32'h0000_FFFF);
    reg_read(2'd0, d);
    check("R1", "status after reset", d, 32'h0);
    check("R1", "irq after reset", {31'b0, irq}, 32'h0);
    set_req(16'hFFFF);
    check("R1", "all masked, disabled", {31'b0, irq}, 32'h0);
    set_req(16'h0000);
  endtask

  task automatic t_status_follow;
    logic [31:0] d;
    set_req(16'hA5C3);
    reg_read(2'd0, d);
    check("R2", "status pattern A5C3", d, 32'h0000_A5C3);
    set_req(16'h8001);
    reg_read(2'd0, d);
    check("R2", "status pattern 8001", d, 32'h0000_8001);
    set_req(16'h0000);
    reg_read(2'd0, d);
    check("R8", "status drops with line", d, 32'h0);
  endtask

  task automatic t_mask_rw;
    logic [31:0] d;
    reg_write(2'd1, 32'hDEAD_1234);
    reg_read(2'd1, d);
    check("R3", "mask readback upper cleared", d, 32'h0000_1234);
    reg_write(2'd1, 32'h0000_0000);
    reg_read(2'd1, d);
    check("R3", "mask all open", d, 32'h0);
  endtask

  task automatic t_enable;
    reg_write(2'd1, 32'h0000_FFFE);
    set_req(16'h0001);
    check("R5", "enable off blocks irq", {31'b0, irq}, 32'h0);
    reg_write(2'd2, 32'hFFEF_FFFF);
    check("R5", "other control bits ignored", {31'b0, irq}, 32'h0);
    reg_write(2'd2, 32'h0010_0000);
    check("R5", "bit 20 enables irq", {31'b0, irq}, 32'h1);
    reg_write(2'd2, 32'h0000_0000);
    check("R5", "bit 20 cleared", {31'b0, irq}, 32'h0);
    set_req(16'h0000);
  endtask

  task automatic t_irq_combos;
    reg_write(2'd2, 32'h0010_0000);
    reg_write(2'd1, 32'h0000_7FFF);
    set_req(16'h7FFF);
    check("R4", "only masked channels pending", {31'b0, irq}, 32'h0);
    set_req(16'h8000);
    check("R4", "channel 15 unmasked pending", {31'b0, irq}, 32'h1);
    set_req(16'hC000);
    set_req(16'h4000);
    check("R8", "irq falls when line drops", {31'b0, irq}, 32'h0);
    reg_write(2'd1, 32'h0000_BFFF);
    check("R3", "unmask channel 14", {31'b0, irq}, 32'h1);
    set_req(16'h0000);
    check("R8", "no request, no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask_timing;
    reg_write(2'd1, 32'h0000_FFFF);
    set_req(16'h0010);
    check("R6", "masked before write", {31'b0, irq}, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0000_FFEF;
    #1;
    check("R6", "write pending, irq unchanged", {31'b0, irq}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R6", "irq after write edge", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_status_write;
    logic [31:0] d;
    reg_write(2'd0, 32'h0000_FFFF);
    reg_read(2'd0, d);
    check("R7", "status unchanged by write", d, 32'h0000_0010);
    reg_read(2'd1, d);
    check("R7", "mask unchanged by status write", d, 32'h0000_FFEF);
    check("R7", "irq unchanged", {31'b0, irq}, 32'h1);
    reg_read(2'd2, d);
    check("R9", "control reads zero", d, 32'h0);
    reg_read(2'd3, d);
    check("R9", "spare reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_follow();
    t_mask_rw();
    t_enable();
    t_irq_combos();
    t_mask_timing();
    t_status_write();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule